// File: doc/BRIEF.md
# Video Reference Field Selector

This block watches the horizontal, vertical and field reference inputs of an interlaced video source. It samples them only on the system clock edges that a half-rate clock qualifier allows. From them it decides whether the field that is starting should be processed, and it marks the line where processing begins. The field can be identified internally, by measuring how many qualified clocks separate the vertical active edge from the latest horizontal active edge. It can also be taken from an external field input. A split-screen mode keeps both fields and pushes the start line further down the picture.

Downstream logic uses `field_act` as a gate for the selected field. It uses `line_start` as the one-sample marker of the first line to process, and `field_det` to learn which field was seen.

Top module: `vid_field_sel`

## Requirements
- R1: Reference inputs are sampled only on rising clock edges where `qual` is high. A pulse that is present only while `qual` is low has no effect, and the outputs change only on qualified edges.
- R2: `h_rise` and `v_rise` each choose the active edge of their reference input: 1 selects low-to-high and 0 selects high-to-low. The opposite transition is never counted. After reset, the first qualified sample only primes the edge detectors.
- R3: In 625-line mode (`std525`=0), a vertical active edge that falls 1 to 432 qualified samples after the latest horizontal active edge is Field 1, shown as `field_det`=0. A spacing of 433 or more is Field 2, shown as `field_det`=1.
- R4: In 525-line mode (`std525`=1), the Field 1 window is 1 to 429 qualified samples, and a spacing of 430 gives Field 2.
- R5: A horizontal and a vertical active edge in the same qualified sample give Field 1.
- R6: The spacing count saturates and never wraps. A vertical edge more than 1023 samples after the last horizontal edge gives Field 2, and so does a vertical edge with no horizontal edge since reset.
- R7: With `fdet_ext`=0, the internally detected field is used. `fsel`=0 keeps Field 1 and `fsel`=1 keeps Field 2. A field that is not kept produces no `line_start` and no `field_act`.
- R8: With `fdet_ext`=1, `fref_in` is sampled at the vertical active edge and reported on `field_det`. The field is kept when that level equals `fsel`.
- R9: For a kept field, `line_start` pulses on horizontal active edge number `line_ofs`+1 after the vertical active edge. A horizontal edge in the same sample as the vertical edge is not counted.
- R10: With `split_en`=1, every field is kept whatever `fsel` and the detected field are. The start moves to horizontal edge number `line_ofs`+73.
- R11: `line_start` lasts exactly one qualified sample. `field_act` rises together with it and falls at the next vertical active edge.
- R12: After reset all outputs are 0. `field_det` changes only at a vertical active edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qual | input | 1 | Clock qualifier; inputs are sampled only while it is high |
| href_in | input | 1 | Horizontal reference |
| vref_in | input | 1 | Vertical reference |
| fref_in | input | 1 | External field reference |
| h_rise | input | 1 | 1: horizontal active edge is rising; 0: falling |
| v_rise | input | 1 | 1: vertical active edge is rising; 0: falling |
| fdet_ext | input | 1 | 1: use `fref_in`; 0: use internal timing detection |
| fsel | input | 1 | Field to keep (0 = Field 1, 1 = Field 2) |
| std525 | input | 1 | 1: 525-line window limit; 0: 625-line limit |
| split_en | input | 1 | Keep both fields and add the split-screen line delay |
| line_ofs | input | 6 | Number of horizontal edges to skip before the start line |
| field_act | output | 1 | Processing of the kept field is active |
| line_start | output | 1 | One-sample marker of the first processed line |
| field_det | output | 1 | Field seen at the last vertical edge (1 = Field 2 or high `fref_in`) |

## Verification
Every result is registered once. It therefore appears right after the qualified rising edge that samples the stimulus, and it cannot move before the next qualified edge. The bench changes inputs and raises `qual` on a falling edge, then lowers `qual` on the next falling edge. It reads the outputs at that point, one qualified edge after the stimulus. Stimulus is counted in qualified samples, so window limits such as 432/433 and 429/430 are hit exactly. The single-sample length of `line_start` is confirmed by reading it again one qualified step later.

// File: rtl/vfs_pkg.sv
package vfs_pkg;

  // Field identities as reported on the field indicator
  typedef enum logic {
    FIELD_ONE = 1'b0,
    FIELD_TWO = 1'b1
  } field_e;

  // True when the sampled level pair forms the chosen active transition
  function automatic logic active_edge(input logic now, input logic prev, input logic rising);
    return rising ? (now & ~prev) : (~now & prev);
  endfunction

  // Field 1 when the spacing (prev_count + 1) lies inside the window, or on coincidence
  function automatic logic in_window(input int unsigned prev_count, input int unsigned limit,
                                     input logic coincident);
    return coincident || (prev_count < limit);
  endfunction

endpackage

// File: rtl/vfs_edge_det.sv
module vfs_edge_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] rising,
  output logic [N-1:0] act
);
  import vfs_pkg::*;

  logic         primed;
  logic [N-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed <= 1'b0;
      prev   <= '0;
    end else if (ce) begin
      primed <= 1'b1;
      prev   <= lvl;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign act[i] = ce & primed & active_edge(lvl[i], prev[i], rising[i]);
  end

endmodule

// File: rtl/vfs_field_det.sv
module vfs_field_det #(
  parameter int CNT_W   = 10,
  parameter int LIM_625 = 432,
  parameter int LIM_525 = 429
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic h_act,
  input  logic v_act,
  input  logic std525,
  input  logic fdet_ext,
  input  logic fref_lvl,
  input  logic fsel,
  input  logic split_en,
  output logic keep,
  output logic field_det
);
  import vfs_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] spc_cnt;
  logic             near;
  logic             field_now;
  int unsigned      limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      spc_cnt <= CNT_MAX;
    else if (ce) begin
      if (h_act)
        spc_cnt <= '0;
      else if (spc_cnt != CNT_MAX)
        spc_cnt <= spc_cnt + 1'b1;
    end
  end

  always_comb begin
    limit     = std525 ? LIM_525 : LIM_625;
    near      = in_window(int'(spc_cnt), limit, h_act);
    field_now = fdet_ext ? fref_lvl : (near ? FIELD_ONE : FIELD_TWO);
    keep      = split_en | (field_now == fsel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      field_det <= FIELD_ONE;
    else if (v_act)
      field_det <= field_now;
  end

endmodule

// File: rtl/vfs_line_seq.sv
module vfs_line_seq #(
  parameter int LOFS_W      = 6,
  parameter int SPLIT_LINES = 72
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              h_act,
  input  logic              v_act,
  input  logic              keep,
  input  logic              split_en,
  input  logic [LOFS_W-1:0] line_ofs,
  output logic              line_start,
  output logic              field_act
);

  localparam int TGT_W = $clog2((1 << LOFS_W) + SPLIT_LINES + 1);

  logic             armed;
  logic [TGT_W-1:0] lcnt;
  logic [TGT_W-1:0] target;
  logic             hit;

  always_comb begin
    target = TGT_W'(line_ofs) + (split_en ? TGT_W'(SPLIT_LINES) : '0);
    hit    = armed & h_act & ~v_act & (lcnt == target);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      lcnt       <= '0;
      line_start <= 1'b0;
      field_act  <= 1'b0;
    end else if (ce) begin
      line_start <= hit;
      if (v_act) begin
        field_act <= 1'b0;
        armed     <= keep;
        lcnt      <= '0;
      end else if (h_act && armed) begin
        if (hit) begin
          armed     <= 1'b0;
          field_act <= 1'b1;
        end else begin
          lcnt <= lcnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/vid_field_sel.sv
module vid_field_sel #(
  parameter int LOFS_W      = 6,
  parameter int SPLIT_LINES = 72,
  parameter int CNT_W       = 10,
  parameter int LIM_625     = 432,
  parameter int LIM_525     = 429
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              qual,
  input  logic              href_in,
  input  logic              vref_in,
  input  logic              fref_in,
  input  logic              h_rise,
  input  logic              v_rise,
  input  logic              fdet_ext,
  input  logic              fsel,
  input  logic              std525,
  input  logic              split_en,
  input  logic [LOFS_W-1:0] line_ofs,
  output logic              field_act,
  output logic              line_start,
  output logic              field_det
);

  localparam int H_IDX = 0;
  localparam int V_IDX = 1;

  logic [1:0] ref_act;
  logic       h_act;
  logic       v_act;
  logic       keep;

  vfs_edge_det #(.N(2)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce     (qual),
    .lvl    ({vref_in, href_in}),
    .rising ({v_rise, h_rise}),
    .act    (ref_act)
  );

  assign h_act = ref_act[H_IDX];
  assign v_act = ref_act[V_IDX];

  vfs_field_det #(.CNT_W(CNT_W), .LIM_625(LIM_625), .LIM_525(LIM_525)) u_fdet (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce        (qual),
    .h_act     (h_act),
    .v_act     (v_act),
    .std525    (std525),
    .fdet_ext  (fdet_ext),
    .fref_lvl  (fref_in),
    .fsel      (fsel),
    .split_en  (split_en),
    .keep      (keep),
    .field_det (field_det)
  );

  vfs_line_seq #(.LOFS_W(LOFS_W), .SPLIT_LINES(SPLIT_LINES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce         (qual),
    .h_act      (h_act),
    .v_act      (v_act),
    .keep       (keep),
    .split_en   (split_en),
    .line_ofs   (line_ofs),
    .line_start (line_start),
    .field_act  (field_act)
  );

endmodule

// File: rtl/vfs_checker.sv
module vfs_checker (
  input logic clk,
  input logic rst_n,
  input logic qual,
  input logic h_act,
  input logic v_act,
  input logic line_start,
  input logic field_act,
  input logic field_det
);

  // R1
  qual_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !qual |=> ($stable(line_start) && $stable(field_act) && $stable(field_det)));

  // R1
  unqual_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !qual |-> (!h_act && !v_act));

  // R11
  strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && qual) |=> !line_start);

  // R11
  strobe_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> field_act);

  // R11
  vclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_act |=> !field_act);

  // R11
  act_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(field_act) |-> $past(v_act));

  // R12
  det_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !v_act |=> $stable(field_det));

endmodule

bind vid_field_sel vfs_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .qual       (qual),
  .h_act      (h_act),
  .v_act      (v_act),
  .line_start (line_start),
  .field_act  (field_act),
  .field_det  (field_det)
);

// File: tb/tb_vid_field_sel.sv
module tb_vid_field_sel;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       qual = 1'b0;
  logic       href_in, vref_in, fref_in;
  logic       h_rise, v_rise, fdet_ext, fsel, std525, split_en;
  logic [5:0] line_ofs;
  logic       field_act, line_start, field_det;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_field_sel dut (
    .clk(clk), .rst_n(rst_n), .qual(qual),
    .href_in(href_in), .vref_in(vref_in), .fref_in(fref_in),
    .h_rise(h_rise), .v_rise(v_rise), .fdet_ext(fdet_ext), .fsel(fsel),
    .std525(std525), .split_en(split_en), .line_ofs(line_ofs),
    .field_act(field_act), .line_start(line_start), .field_det(field_det)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one qualified sample with the given active/idle state of H and V
  task automatic qs(input bit h_on, input bit v_on);
    @(negedge clk);
    href_in = h_on ? h_rise : ~h_rise;
    vref_in = v_on ? v_rise : ~v_rise;
    qual    = 1'b1;
    @(negedge clk);
    qual    = 1'b0;
  endtask

  task automatic do_reset(input bit hr, input bit vr);
    @(negedge clk);
    rst_n = 1'b0; qual = 1'b0;
    h_rise = hr; v_rise = vr;
    href_in = ~hr; vref_in = ~vr; fref_in = 1'b0;
    fdet_ext = 0; fsel = 0; std525 = 0; split_en = 0; line_ofs = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    qs(0, 0);
  endtask

  // H edge, V edge d samples later (d=0: same sample), then nh H edges
  task automatic frame(input int d, input int nh, output int first_k, output bit long_strobe);
    first_k = 0;
    long_strobe = 0;
    if (d == 0) qs(1, 1);
    else begin
      qs(1, 0);
      for (int i = 1; i < d; i++) qs(0, 0);
      qs(0, 1);
    end
    qs(0, 0);
    for (int k = 1; k <= nh; k++) begin
      qs(1, 0);
      if (line_start && first_k == 0) first_k = k;
      qs(0, 0);
      if (line_start) long_strobe = 1;
    end
  endtask

  task automatic t_reset();
    int fk; bit ls;
    do_reset(1, 1);
    check("R12 reset field_act", field_act, 0);
    check("R12 reset line_start", line_start, 0);
    check("R12 reset field_det", field_det, 0);
    // R6: V with no H edge since reset
    qs(0, 1); qs(0, 0);
    check("R6 no H since reset -> field 2", field_det, 1);
    fk = 0; ls = 0;
  endtask

  task automatic t_window();
    int fk; bit ls;
    do_reset(1, 1);
    frame(1, 0, fk, ls);   check("R3 spacing 1 -> field 1", field_det, 0);
    frame(432, 0, fk, ls); check("R3 spacing 432 -> field 1", field_det, 0);
    frame(433, 0, fk, ls); check("R3 spacing 433 -> field 2", field_det, 1);
    std525 = 1;
    frame(429, 0, fk, ls); check("R4 spacing 429 -> field 1", field_det, 0);
    frame(430, 0, fk, ls); check("R4 spacing 430 -> field 2", field_det, 1);
    std525 = 0;
    frame(0, 0, fk, ls);   check("R5 coincident -> field 1", field_det, 0);
    frame(1100, 0, fk, ls); check("R6 saturated spacing -> field 2", field_det, 1);
  endtask

  task automatic t_lines();
    int fk; bit ls;
    do_reset(1, 1);
    line_ofs = 6'd3;
    frame(5, 6, fk, ls);
    check("R9 start on H edge ofs+1", fk, 4);
    check("R11 strobe one sample", ls, 0);
    check("R11 field_act held", field_act, 1);
    // unqualified V pulse must be ignored
    @(negedge clk); vref_in = v_rise;
    @(negedge clk); vref_in = ~v_rise;
    qs(0, 0);
    check("R1 unqualified V ignored (field_act)", field_act, 1);
    check("R1 unqualified V ignored (field_det)", field_det, 0);
    // field 2 while fsel=0: not kept
    frame(500, 8, fk, ls);
    check("R11 field_act cleared at V", field_act, 0);
    check("R7 field 2 dropped with fsel=0", fk, 0);
    fsel = 1;
    frame(500, 8, fk, ls);
    check("R7 field 2 kept with fsel=1", fk, 4);
    frame(5, 8, fk, ls);
    check("R7 field 1 dropped with fsel=1", fk, 0);
  endtask

  task automatic t_polarity();
    int fk; bit ls;
    do_reset(0, 0);
    frame(2, 3, fk, ls);
    check("R2 falling edges: field", field_det, 0);
    check("R2 falling edges: start", fk, 1);
    do_reset(1, 0);
    frame(3, 3, fk, ls);
    check("R2 mixed edges: field", field_det, 0);
    check("R2 mixed edges: start", fk, 1);
    check("R2 mixed edges: field_act", field_act, 1);
  endtask

  task automatic t_external();
    int fk; bit ls;
    do_reset(1, 1);
    fdet_ext = 1; fsel = 1; line_ofs = 6'd1;
    fref_in = 1;
    frame(5, 4, fk, ls);
    check("R8 fref=1 reported", field_det, 1);
    check("R8 fref matches fsel -> kept", fk, 2);
    fref_in = 0;
    frame(600, 4, fk, ls);
    check("R8 fref=0 reported", field_det, 0);
    check("R8 fref differs -> dropped", fk, 0);
  endtask

  task automatic t_split();
    int fk; bit ls;
    do_reset(1, 1);
    split_en = 1; line_ofs = 6'd2; fsel = 0;
    frame(600, 80, fk, ls);
    check("R10 split keeps field 2, start ofs+73", fk, 75);
    frame(3, 80, fk, ls);
    check("R10 split keeps field 1, start ofs+73", fk, 75);
  endtask

  initial begin
    t_reset();
    t_window();
    t_lines();
    t_polarity();
    t_external();
    t_split();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule